// File: doc/BRIEF.md
# DSP Address Generation Unit

This block produces one data-memory address per cycle for a fixed-point DSP datapath. It keeps a small bank of pointer registers, each paired with its own buffer base and modulo length, together with one shared index register and one shared bit-reversal field width. Each cycle a decoded operation selects a pointer and an update rule. The unit then returns the effective address and, when the rule updates the pointer, the new pointer value and its register number.

The update rules include stepping by one access, stepping by a scaled 5-bit immediate before or after the access, stepping by the index register, and reading at pointer plus index with no update. Any pointer whose modulo length is nonzero wraps inside its circular buffer. A reverse-carry step moves through FFT operands in bit-reversed order over a programmable field. An access spans 1, 2 or 4 words and must be aligned to that count. A misaligned request is flagged and leaves the pointer unchanged. All outputs are registered, so the result of an operation appears one clock after it is presented. The register bank is written at that same edge, so back-to-back operations on one pointer see each other's updates.

Top module: `dsp_agu`

## Requirements
- R1: A synchronous active-high reset clears acc_o, err_o and wb_en_o and sets every pointer, base, modulo, index and field-width register to zero. Outputs are registered: an operation presented at one rising edge is reflected on the outputs right after that edge.
- R2: The set operations load wdata_i into a register of the selected pointer and produce no access (acc_o=0, wb_en_o=0). The codes are 1 for pointer, 2 for base and 3 for modulo length. Code 4 loads the shared index register and code 5 loads the field width from the low bits of wdata_i. Code 0 does nothing.
- R3: Code 6 (plain) gives acc_o=1 and addr_o equal to the pointer, with no write-back.
- R4: Code 7 (post step up) and code 8 (post step down) output the old pointer as the address and write back the pointer plus or minus the access size in words. The width code maps 0 to 1 word, 1 to 2 words, and 2 or 3 to 4 words.
- R5: Code 9 (pre add) and code 10 (pre subtract) compute the pointer plus or minus imm_i times the access size, with imm_i unsigned. That value is both the output address and the write-back value.
- R6: Code 11 (post add) and code 12 (post subtract) output the old pointer and write back the pointer plus or minus imm_i times the access size.
- R7: Code 13 (indexed) outputs the pointer plus the index register and leaves the pointer unchanged. Code 14 (post index) outputs the old pointer and writes back the pointer plus the index register.
- R8: When the selected modulo length M is nonzero, a stepped pointer that reaches base+M or beyond has M subtracted, and one that falls below base has M added. The output address of a pre-mode follows the wrapped value.
- R9: Code 15 (reverse carry) outputs the old pointer and writes back a new pointer. Inside the low N bits, where N is the field width, it is the pointer plus the index register with the carry running from the field's top bit toward bit 0. Bits above the field are unchanged.
- R10: If the effective address is not a multiple of the access size, err_o=1 with acc_o=1, wb_en_o=0, and the pointer keeps its value.
- R11: With a modulo length of zero, pointer arithmetic wraps modulo 2^AW (0 stepped down by one gives all ones).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| sel_i | input | SW | Pointer register select |
| imm_i | input | IMMW | Unsigned immediate step |
| width_i | input | 2 | Access size code |
| wdata_i | input | AW | Value for set operations |
| acc_o | output | 1 | An access was performed |
| addr_o | output | AW | Effective address |
| err_o | output | 1 | Misaligned access |
| wb_en_o | output | 1 | Pointer was updated |
| wb_sel_o | output | SW | Updated pointer number |
| wb_ptr_o | output | AW | Updated pointer value |

## Verification
The bench builds the block with its defaults: 16-bit addresses, four pointers and a 5-bit immediate. These widths let a decrement from zero reach the all-ones top of the address space. They also allow the reverse-carry step to be driven both over a 3-bit field, giving an 8-point FFT order, and over the full 16-bit word. With four pointers, one can hold a circular buffer while the others stay linear, so per-pointer modulo settings are tested in isolation.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_SETP    = 4'd1,
    OP_SETB    = 4'd2,
    OP_SETM    = 4'd3,
    OP_SETX    = 4'd4,
    OP_SETN    = 4'd5,
    OP_LIN     = 4'd6,
    OP_STEPUP  = 4'd7,
    OP_STEPDN  = 4'd8,
    OP_PREADD  = 4'd9,
    OP_PRESUB  = 4'd10,
    OP_POSTADD = 4'd11,
    OP_POSTSUB = 4'd12,
    OP_IDX     = 4'd13,
    OP_POSTIDX = 4'd14,
    OP_BREV    = 4'd15
  } agu_op_e;

  function automatic logic [1:0] width_shift(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int AW   = 16,
  parameter int NREG = 4,
  parameter int SW   = 2,
  parameter int NW   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] sel,
  input  logic          p_we,
  input  logic [AW-1:0] p_d,
  input  logic          b_we,
  input  logic          m_we,
  input  logic          x_we,
  input  logic          n_we,
  input  logic [AW-1:0] cfg_d,
  input  logic [NW-1:0] n_d,
  output logic [AW-1:0] p_q,
  output logic [AW-1:0] b_q,
  output logic [AW-1:0] m_q,
  output logic [AW-1:0] x_q,
  output logic [NW-1:0] n_q
);

  logic [AW-1:0] ptr_r  [NREG];
  logic [AW-1:0] base_r [NREG];
  logic [AW-1:0] mod_r  [NREG];
  logic [AW-1:0] idx_r;
  logic [NW-1:0] nbit_r;

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_r[g]  <= '0;
        base_r[g] <= '0;
        mod_r[g]  <= '0;
      end else if (int'(sel) == g) begin
        if (p_we) ptr_r[g]  <= p_d;
        if (b_we) base_r[g] <= cfg_d;
        if (m_we) mod_r[g]  <= cfg_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_r  <= '0;
      nbit_r <= '0;
    end else begin
      if (x_we) idx_r  <= cfg_d;
      if (n_we) nbit_r <= n_d;
    end
  end

  assign p_q = ptr_r[sel];
  assign b_q = base_r[sel];
  assign m_q = mod_r[sel];
  assign x_q = idx_r;
  assign n_q = nbit_r;

endmodule

// File: rtl/agu_step.sv
module agu_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0]      ptr,
  input  logic [AW-1:0]      base,
  input  logic [AW-1:0]      modlen,
  input  logic signed [AW:0] delta,
  output logic [AW-1:0]      next
);

  localparam int EW = AW + 2;

  logic signed [EW-1:0] sum;
  logic signed [EW-1:0] lo;
  logic signed [EW-1:0] hi;
  logic signed [EW-1:0] mext;
  logic signed [EW-1:0] wrapped;

  always_comb begin
    sum  = $signed({2'b00, ptr}) + EW'(delta);
    lo   = $signed({2'b00, base});
    mext = $signed({2'b00, modlen});
    hi   = lo + mext;
    wrapped = sum;
    if (modlen != '0) begin
      if (sum >= hi)     wrapped = sum - mext;
      else if (sum < lo) wrapped = sum + mext;
    end
    next = wrapped[AW-1:0];
  end

endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
  parameter int AW = 16,
  parameter int NW = 5
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [NW-1:0] nbits,
  output logic [AW-1:0] next
);

  localparam logic [NW-1:0] AWN = NW'(AW);

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  logic [NW-1:0] nn;
  logic [NW-1:0] sh;
  logic [AW-1:0] mask;
  logic [AW-1:0] ra;
  logic [AW-1:0] rb;
  logic [AW-1:0] rs;
  logic [AW-1:0] back;

  always_comb begin
    nn   = (nbits > AWN) ? AWN : nbits;
    sh   = AWN - nn;
    mask = {AW{1'b1}} >> sh;
    ra   = flip(ptr & mask) >> sh;
    rb   = flip(step & mask) >> sh;
    rs   = (ra + rb) & mask;
    back = flip(rs) >> sh;
    next = (ptr & ~mask) | (back & mask);
  end

endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
  import agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 4,
  parameter int IMMW = 5,
  localparam int SW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      op_i,
  input  logic [SW-1:0]   sel_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [1:0]      width_i,
  input  logic [AW-1:0]   wdata_i,
  output logic            acc_o,
  output logic [AW-1:0]   addr_o,
  output logic            err_o,
  output logic            wb_en_o,
  output logic [SW-1:0]   wb_sel_o,
  output logic [AW-1:0]   wb_ptr_o
);

  localparam int NW = $clog2(AW + 1);

  agu_op_e       op;
  logic [1:0]    wsh;
  logic [AW-1:0] words;
  logic [AW-1:0] imm_sc;
  logic [AW-1:0] p_q, b_q, m_q, x_q;
  logic [NW-1:0] n_q;
  logic signed [AW:0] delta;
  logic [AW-1:0] step_next;
  logic [AW-1:0] brev_next;
  logic [AW-1:0] upd;
  logic [AW-1:0] eff;
  logic          is_acc;
  logic          does_upd;
  logic          misal;
  logic          p_we;

  assign op     = agu_op_e'(op_i);
  assign wsh    = width_shift(width_i);
  assign words  = AW'(1) << wsh;
  assign imm_sc = {{(AW-IMMW){1'b0}}, imm_i} << wsh;

  agu_regfile #(.AW(AW), .NREG(NREG), .SW(SW), .NW(NW)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .sel   (sel_i),
    .p_we  (p_we),
    .p_d   ((op == OP_SETP) ? wdata_i : upd),
    .b_we  (op == OP_SETB),
    .m_we  (op == OP_SETM),
    .x_we  (op == OP_SETX),
    .n_we  (op == OP_SETN),
    .cfg_d (wdata_i),
    .n_d   (wdata_i[NW-1:0]),
    .p_q   (p_q),
    .b_q   (b_q),
    .m_q   (m_q),
    .x_q   (x_q),
    .n_q   (n_q)
  );

  always_comb begin
    unique case (op)
      OP_STEPUP:             delta =  $signed({1'b0, words});
      OP_STEPDN:             delta = -$signed({1'b0, words});
      OP_PREADD, OP_POSTADD: delta =  $signed({1'b0, imm_sc});
      OP_PRESUB, OP_POSTSUB: delta = -$signed({1'b0, imm_sc});
      OP_POSTIDX:            delta =  $signed({1'b0, x_q});
      default:               delta = '0;
    endcase
  end

  agu_step #(.AW(AW)) u_step (
    .ptr    (p_q),
    .base   (b_q),
    .modlen (m_q),
    .delta  (delta),
    .next   (step_next)
  );

  agu_bitrev #(.AW(AW), .NW(NW)) u_brev (
    .ptr   (p_q),
    .step  (x_q),
    .nbits (n_q),
    .next  (brev_next)
  );

  always_comb begin
    upd = (op == OP_BREV) ? brev_next : step_next;
    unique case (op)
      OP_PREADD, OP_PRESUB: eff = upd;
      OP_IDX:               eff = p_q + x_q;
      default:              eff = p_q;
    endcase
    is_acc   = (op_i >= 4'd6);
    does_upd = is_acc && (op != OP_LIN) && (op != OP_IDX);
    misal    = |(eff & (words - AW'(1)));
    p_we     = (op == OP_SETP) || (does_upd && !misal);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o    <= 1'b0;
      addr_o   <= '0;
      err_o    <= 1'b0;
      wb_en_o  <= 1'b0;
      wb_sel_o <= '0;
      wb_ptr_o <= '0;
    end else begin
      acc_o    <= is_acc;
      addr_o   <= eff;
      err_o    <= is_acc && misal;
      wb_en_o  <= does_upd && !misal;
      wb_sel_o <= sel_i;
      wb_ptr_o <= upd;
    end
  end

endmodule

// File: rtl/dsp_agu_chk.sv
module dsp_agu_chk #(
  parameter int AW = 16,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    op_i,
  input logic [SW-1:0] sel_i,
  input logic [1:0]    width_i,
  input logic          acc_o,
  input logic [AW-1:0] addr_o,
  input logic          err_o,
  input logic          wb_en_o,
  input logic [SW-1:0] wb_sel_o,
  input logic [AW-1:0] wb_ptr_o
);

  logic [1:0]    w_q;
  logic [AW-1:0] amask;

  always_ff @(posedge clk) w_q <= width_i;
  assign amask = (AW'(1) << ((w_q == 2'd3) ? 2'd2 : w_q)) - AW'(1);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!acc_o && !err_o && !wb_en_o));

  // R2
  cfg_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(op_i) <= 4'd5) |-> (!acc_o && !wb_en_o));

  // R3
  plain_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(op_i) == 4'd6) |-> (acc_o && !wb_en_o));

  // R3
  chain_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wb_en_o) && ($past(op_i) == 4'd6) && ($past(sel_i) == $past(wb_sel_o)))
      |-> (addr_o == $past(wb_ptr_o)));

  // R4
  step_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(op_i) == 4'd7) && !err_o) |-> (acc_o && wb_en_o));

  // R10
  err_blocks_wb_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (acc_o && !wb_en_o));

  // R10
  align_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_o && !err_o) |-> ((addr_o & amask) == '0));

endmodule

bind dsp_agu dsp_agu_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_i     (op_i),
  .sel_i    (sel_i),
  .width_i  (width_i),
  .acc_o    (acc_o),
  .addr_o   (addr_o),
  .err_o    (err_o),
  .wb_en_o  (wb_en_o),
  .wb_sel_o (wb_sel_o),
  .wb_ptr_o (wb_ptr_o)
);

// File: tb/dsp_agu_tb.sv
module dsp_agu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    op_i = '0;
  logic [SW-1:0] sel_i = '0;
  logic [4:0]    imm_i = '0;
  logic [1:0]    width_i = '0;
  logic [AW-1:0] wdata_i = '0;
  logic          acc_o, err_o, wb_en_o;
  logic [AW-1:0] addr_o, wb_ptr_o;
  logic [SW-1:0] wb_sel_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_agu u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .sel_i(sel_i), .imm_i(imm_i),
    .width_i(width_i), .wdata_i(wdata_i), .acc_o(acc_o), .addr_o(addr_o),
    .err_o(err_o), .wb_en_o(wb_en_o), .wb_sel_o(wb_sel_o), .wb_ptr_o(wb_ptr_o)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, result sampled 1 time unit after the next rising edge
  task automatic run(input logic [3:0] o, input logic [SW-1:0] s, input logic [4:0] im,
                     input logic [1:0] w, input logic [AW-1:0] d);
    op_i = o; sel_i = s; imm_i = im; width_i = w; wdata_i = d;
    @(posedge clk); #1;
    @(negedge clk);
    op_i = 4'd0;
  endtask

  task automatic acc_expect(input string tag, input logic [AW-1:0] a,
                            input logic wb, input logic [AW-1:0] p, input logic e);
    chk({tag, " acc"}, AW'(acc_o), AW'(1));
    chk({tag, " addr"}, addr_o, a);
    chk({tag, " err"}, AW'(err_o), AW'(e));
    chk({tag, " wb_en"}, AW'(wb_en_o), AW'(wb));
    if (wb) chk({tag, " wb_ptr"}, wb_ptr_o, p);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 acc after reset", AW'(acc_o), '0);
    chk("R1 err after reset", AW'(err_o), '0);
    chk("R1 wb_en after reset", AW'(wb_en_o), '0);
    rst = 1'b0;
    run(4'd6, 2'd2, 0, 0, 0);
    acc_expect("R1 pointer zero", 16'h0000, 0, 0, 0);
  endtask

  task automatic t_config_plain;
    run(4'd1, 2'd1, 0, 0, 16'h1234);
    chk("R2 set no acc", AW'(acc_o), '0);
    chk("R2 set no wb", AW'(wb_en_o), '0);
    run(4'd6, 2'd1, 0, 0, 0);
    acc_expect("R3 plain", 16'h1234, 0, 0, 0);
    run(4'd6, 2'd1, 0, 0, 0);
    acc_expect("R3 plain repeat", 16'h1234, 0, 0, 0);
  endtask

  task automatic t_post_step;
    run(4'd1, 2'd0, 0, 0, 16'h0100);
    run(4'd7, 2'd0, 0, 2'd0, 0);
    acc_expect("R4 step up 1", 16'h0100, 1, 16'h0101, 0);
    chk("R4 wb_sel", AW'(wb_sel_o), 16'd0);
    run(4'd1, 2'd0, 0, 0, 16'h0200);
    run(4'd7, 2'd0, 0, 2'd2, 0);
    acc_expect("R4 step up 4", 16'h0200, 1, 16'h0204, 0);
    run(4'd8, 2'd0, 0, 2'd1, 0);
    acc_expect("R4 step down 2", 16'h0204, 1, 16'h0202, 0);
    run(4'd6, 2'd0, 0, 0, 0);
    acc_expect("R4 pointer kept", 16'h0202, 0, 0, 0);
  endtask

  task automatic t_pre_imm;
    run(4'd1, 2'd2, 0, 0, 16'h0040);
    run(4'd9, 2'd2, 5'd3, 2'd1, 0);
    acc_expect("R5 pre add x2", 16'h0046, 1, 16'h0046, 0);
    run(4'd10, 2'd2, 5'd5, 2'd0, 0);
    acc_expect("R5 pre sub", 16'h0041, 1, 16'h0041, 0);
  endtask

  task automatic t_post_imm;
    run(4'd1, 2'd3, 0, 0, 16'h0080);
    run(4'd11, 2'd3, 5'd31, 2'd0, 0);
    acc_expect("R6 post add 31", 16'h0080, 1, 16'h009F, 0);
    run(4'd1, 2'd3, 0, 0, 16'h0080);
    run(4'd12, 2'd3, 5'd4, 2'd2, 0);
    acc_expect("R6 post sub x4", 16'h0080, 1, 16'h0070, 0);
  endtask

  task automatic t_index;
    run(4'd4, 2'd0, 0, 0, 16'h0010);
    run(4'd1, 2'd1, 0, 0, 16'h0300);
    run(4'd13, 2'd1, 0, 2'd0, 0);
    acc_expect("R7 indexed", 16'h0310, 0, 0, 0);
    run(4'd6, 2'd1, 0, 0, 0);
    acc_expect("R7 indexed no update", 16'h0300, 0, 0, 0);
    run(4'd14, 2'd1, 0, 2'd0, 0);
    acc_expect("R7 post index", 16'h0300, 1, 16'h0310, 0);
  endtask

  task automatic t_circular;
    run(4'd2, 2'd2, 0, 0, 16'h0100);
    run(4'd3, 2'd2, 0, 0, 16'd10);
    run(4'd1, 2'd2, 0, 0, 16'h0108);
    run(4'd11, 2'd2, 5'd3, 2'd0, 0);
    acc_expect("R8 wrap top", 16'h0108, 1, 16'h0101, 0);
    run(4'd12, 2'd2, 5'd2, 2'd0, 0);
    acc_expect("R8 wrap bottom", 16'h0101, 1, 16'h0109, 0);
    run(4'd9, 2'd2, 5'd1, 2'd0, 0);
    acc_expect("R8 pre wrap", 16'h0100, 1, 16'h0100, 0);
    run(4'd8, 2'd2, 0, 2'd0, 0);
    acc_expect("R8 step down wrap", 16'h0100, 1, 16'h0109, 0);
  endtask

  task automatic t_bitrev;
    logic [AW-1:0] seq [8];
    seq[0] = 0; seq[1] = 4; seq[2] = 2; seq[3] = 6;
    seq[4] = 1; seq[5] = 5; seq[6] = 3; seq[7] = 7;
    run(4'd5, 2'd0, 0, 0, 16'd3);
    run(4'd4, 2'd0, 0, 0, 16'd4);
    run(4'd1, 2'd0, 0, 0, 16'hA000);
    for (int i = 0; i < 8; i++) begin
      run(4'd15, 2'd0, 0, 2'd0, 0);
      acc_expect("R9 fft order", 16'hA000 | seq[i], 1, 16'hA000 | seq[(i + 1) % 8], 0);
    end
    run(4'd5, 2'd0, 0, 0, 16'd16);
    run(4'd4, 2'd0, 0, 0, 16'h8000);
    run(4'd1, 2'd0, 0, 0, 16'h8000);
    run(4'd15, 2'd0, 0, 2'd0, 0);
    acc_expect("R9 full field", 16'h8000, 1, 16'h4000, 0);
  endtask

  task automatic t_align;
    run(4'd1, 2'd3, 0, 0, 16'h0401);
    run(4'd6, 2'd3, 0, 2'd1, 0);
    acc_expect("R10 plain misaligned", 16'h0401, 0, 0, 1);
    run(4'd11, 2'd3, 5'd1, 2'd1, 0);
    acc_expect("R10 post misaligned", 16'h0401, 0, 0, 1);
    run(4'd6, 2'd3, 0, 2'd0, 0);
    acc_expect("R10 pointer unchanged", 16'h0401, 0, 0, 0);
    run(4'd1, 2'd3, 0, 0, 16'h0402);
    run(4'd9, 2'd3, 5'd1, 2'd1, 0);
    acc_expect("R10 pre aligned x2", 16'h0404, 1, 16'h0404, 0);
    run(4'd9, 2'd3, 5'd1, 2'd2, 0);
    acc_expect("R10 pre aligned x4", 16'h0408, 1, 16'h0408, 0);
    run(4'd10, 2'd3, 5'd1, 2'd0, 0);
    run(4'd9, 2'd3, 5'd1, 2'd1, 0);
    acc_expect("R10 pre misaligned", 16'h0409, 0, 0, 1);
    run(4'd6, 2'd3, 0, 2'd0, 0);
    acc_expect("R10 pre kept", 16'h0407, 0, 0, 0);
    run(4'd1, 2'd3, 0, 0, 16'h0402);
    run(4'd6, 2'd3, 0, 2'd3, 0);
    acc_expect("R10 code3 as 4 words", 16'h0402, 0, 0, 1);
  endtask

  task automatic t_linear_wrap;
    run(4'd1, 2'd0, 0, 0, 16'h0000);
    run(4'd8, 2'd0, 0, 2'd0, 0);
    acc_expect("R11 below zero", 16'h0000, 1, 16'hFFFF, 0);
    run(4'd9, 2'd0, 5'd1, 2'd0, 0);
    acc_expect("R11 past top", 16'h0000, 1, 16'h0000, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_config_plain();
    t_post_step();
    t_pre_imm();
    t_post_imm();
    t_index();
    t_circular();
    t_bitrev();
    t_align();
    t_linear_wrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule